// File: doc/BRIEF.md
# Half-Band Rate-Change Filter

This block filters one stream of signed 13-bit samples through a fixed, symmetric 55-tap half-band low-pass FIR. It can double the sample rate, halve it, or pass samples through unchanged. A 2-bit mode input selects the operation. To double the rate, the filter takes one sample every other clock, puts a zero sample into each gap and doubles the gain, so one output leaves on every clock. To halve the rate, the filter keeps every input in its history but produces a result only on every second accepted input. In pass-through mode the sample still goes through the same pipeline, so the delay is the same in every mode.

A second, unfiltered channel runs beside the filtered one. It goes through a delay line whose length is set from 0 to 127 entries. This keeps the unfiltered channel in step with the filtered one.

Both sample streams use valid/ready handshakes. The whole pipeline, the alignment delay included, moves forward only on clocks where `out_ready` is high. When `out_ready` is low, nothing moves: `in_ready` is low and the output holds its value. A held output is not replaced until the consumer takes it. Mode must be held constant between resets.

Top module: `hbf_rate_filter`

## Requirements
- R1: Mode encoding: 0 and 3 select pass-through, 1 selects interpolation and 2 selects decimation. In pass-through, every accepted sample appears unchanged on `out_data` with `out_valid` high.
- R2: A sample accepted in cycle c affects the output seen in cycle c+6, counting only cycles in which `out_ready` is high. This holds in every mode.
- R3: The filter computes acc = 2048·x[n-27] + Σ c_m·(x[n-27-(2m+1)] + x[n-27+(2m+1)]) for m = 0..13. The coefficients are c = 1273, -380, 210, -130, 85, -56, 37, -24, 16, -10, 6, -4, 2, -1, and all other taps are zero. In decimation the output is acc scaled by 2^-12.
- R4: Decimation produces one output for every two accepted inputs, after the 2nd, 4th, 6th and later inputs counted from reset. Two consecutive output cycles never both carry valid results.
- R5: In interpolation, `in_ready` is low in the cycle after each accepted sample. The filter shifts a zero sample into its history in that cycle, produces an output from both the sample and the zero, and scales acc by 2^-11.
- R6: The scaled result is rounded to nearest, with ties going upward. It is then clamped to the range -4096 to 4095.
- R7: While `out_ready` is low, `in_ready` is low and `out_valid` and `out_data` hold their values.
- R8: `aux_out` equals the `aux_in` value from `dly_len` advancing cycles earlier. When `dly_len` is 0, `aux_out` follows `aux_in` in the same cycle.
- R9: After reset, `out_valid` is low, and the filter history and the alignment delay contents are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operation select |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample taken when both are high |
| in_data | input | 13 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer accepts; also advances the pipeline |
| out_data | output | 13 | Signed filtered sample |
| dly_len | input | 7 | Alignment delay length, 0 to 127 |
| aux_in | input | 13 | Unfiltered channel input |
| aux_out | output | 13 | Unfiltered channel, delayed |

## Verification
A bad tap history or coefficient pairing gives wrong output values six advancing cycles after the offending sample enters. That error stays visible for the next 54 samples as well. A bad phase bit shows at once: `in_ready` toggles wrongly in interpolation, or the output cadence shifts by one sample in decimation. A bad alignment-delay cell shows on `aux_out` exactly `dly_len` cycles after it was written. The bench compares every cycle against an arithmetic model, so each of these errors is caught at its first visible cycle.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  localparam int HB_TAPS = 55;
  localparam int HB_CW   = 13;
  localparam int HB_FRAC = 12;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_INTERP = 2'd1,
    MODE_DECIM  = 2'd2,
    MODE_RSV    = 2'd3
  } hbf_mode_e;

  // index 0..13: outer pairs nearest to farthest from centre; 14: centre tap
  function automatic logic signed [HB_CW-1:0] hb_coef(input int idx);
    case (idx)
      0:  hb_coef = 13'sd1273;
      1:  hb_coef = -13'sd380;
      2:  hb_coef = 13'sd210;
      3:  hb_coef = -13'sd130;
      4:  hb_coef = 13'sd85;
      5:  hb_coef = -13'sd56;
      6:  hb_coef = 13'sd37;
      7:  hb_coef = -13'sd24;
      8:  hb_coef = 13'sd16;
      9:  hb_coef = -13'sd10;
      10: hb_coef = 13'sd6;
      11: hb_coef = -13'sd4;
      12: hb_coef = 13'sd2;
      13: hb_coef = -13'sd1;
      default: hb_coef = 13'sd2048;
    endcase
  endfunction
endpackage

// File: rtl/hbf_taps.sv
module hbf_taps #(
  parameter int SW   = 13,
  parameter int TAPS = 55
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift,
  input  logic signed [SW-1:0] din,
  output logic signed [SW-1:0] tap [TAPS]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) tap[i] <= '0;
    end else if (shift) begin
      tap[0] <= din;
      for (int i = 1; i < TAPS; i++) tap[i] <= tap[i-1];
    end
  end
endmodule

// File: rtl/hbf_align_delay.sv
module hbf_align_delay #(
  parameter int W     = 13,
  parameter int LW    = 7,
  localparam int DEPTH = (1 << LW) - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] len,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  logic [W-1:0] line [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
    end else if (en) begin
      line[0] <= din;
      for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
    end
  end

  assign dout = (len == '0) ? din : line[len - 1'b1];

  // R8
  unit_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (en && len == LW'(1)) |=> (len != LW'(1) || dout == $past(din)));
endmodule

// File: rtl/hbf_mac.sv
module hbf_mac #(
  parameter int SW   = 13,
  parameter int CW   = 13,
  parameter int TAPS = 55,
  parameter int ACCW = 32,
  parameter int FRAC = 12,
  localparam int CTR   = (TAPS - 1) / 2,
  localparam int NPAIR = (CTR + 1) / 2,
  localparam int NPROD = NPAIR + 1,
  localparam int NGRP  = (NPROD + 3) / 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 v0,
  input  logic                 interp,
  input  logic                 pass,
  input  logic signed [SW-1:0] tap [TAPS],
  output logic                 out_valid,
  output logic signed [SW-1:0] out_data
);
  localparam logic signed [ACCW-1:0] HI   = ACCW'((2 ** (SW - 1)) - 1);
  localparam logic signed [ACCW-1:0] LO   = -ACCW'(2 ** (SW - 1));
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (FRAC - 1);
  localparam logic signed [ACCW-1:0] QRTR = ACCW'(1) <<< (FRAC - 2);

  logic signed [SW:0]     pre_q  [NPROD];
  logic signed [ACCW-1:0] prod_q [NPROD];
  logic signed [ACCW-1:0] grp_d  [NGRP];
  logic signed [ACCW-1:0] grp_q  [NGRP];
  logic signed [ACCW-1:0] sum_q, rnd;
  logic [4:1]             v_q;
  logic signed [SW-1:0]   raw_q [4];

  // stage 1: fold symmetric pairs
  for (genvar k = 0; k < NPAIR; k++) begin : g_pre
    always_ff @(posedge clk)
      if (en) pre_q[k] <= {tap[CTR-(2*k+1)][SW-1], tap[CTR-(2*k+1)]}
                        + {tap[CTR+(2*k+1)][SW-1], tap[CTR+(2*k+1)]};
  end
  always_ff @(posedge clk) if (en) pre_q[NPAIR] <= {tap[CTR][SW-1], tap[CTR]};

  // stage 2: one multiplier per nonzero coefficient
  for (genvar k = 0; k < NPROD; k++) begin : g_mul
    always_ff @(posedge clk)
      if (en) prod_q[k] <= ACCW'(pre_q[k]) * ACCW'(hbf_pkg::hb_coef(k));
  end

  // stage 3: groups of four
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      grp_d[g] = '0;
      for (int i = 0; i < 4; i++)
        if (g * 4 + i < NPROD) grp_d[g] = grp_d[g] + prod_q[g*4+i];
    end
  end
  always_ff @(posedge clk) if (en) grp_q <= grp_d;

  // stage 4: final sum
  always_ff @(posedge clk) begin
    if (en) begin
      sum_q <= '0;
      for (int g = 0; g < NGRP; g++) sum_q <= sum_q_next(g);
    end
  end
  function automatic logic signed [ACCW-1:0] sum_q_next(input int last);
    logic signed [ACCW-1:0] s;
    s = '0;
    for (int g = 0; g <= last; g++) s = s + grp_q[g];
    return s;
  endfunction

  // stage 5: round half up, clamp
  always_comb begin
    if (interp) rnd = (sum_q + QRTR) >>> (FRAC - 1);
    else        rnd = (sum_q + HALF) >>> FRAC;
    if (rnd > HI)      rnd = HI;
    else if (rnd < LO) rnd = LO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      out_valid <= 1'b0;
      out_data <= '0;
    end else if (en) begin
      v_q <= {v_q[3:1], v0};
      out_valid <= v_q[4];
      out_data <= pass ? raw_q[3] : rnd[SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      raw_q[0] <= tap[0];
      for (int i = 1; i < 4; i++) raw_q[i] <= raw_q[i-1];
    end
  end
endmodule

// File: rtl/hbf_rate_filter.sv
module hbf_rate_filter #(
  parameter int SW    = 13,
  parameter int DLY_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [SW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [SW-1:0] out_data,
  input  logic [DLY_W-1:0]     dly_len,
  input  logic [SW-1:0]        aux_in,
  output logic [SW-1:0]        aux_out
);
  import hbf_pkg::*;
  localparam int TAPS = HB_TAPS;

  logic en, is_int, is_dec, phase, take, shift, v0;
  logic signed [SW-1:0] din;
  logic signed [SW-1:0] tap_w [TAPS];
  logic [2:0] run_q;

  assign en       = out_ready;
  assign is_int   = (mode == MODE_INTERP);
  assign is_dec   = (mode == MODE_DECIM);
  assign in_ready = en & ~(is_int & phase);
  assign take     = in_valid & in_ready;
  assign shift    = en & (take | (is_int & phase));
  assign din      = (is_int & phase) ? '0 : in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      v0 <= 1'b0;
    end else if (en) begin
      if (is_int)      phase <= phase ? 1'b0 : take;
      else if (is_dec) phase <= take ? ~phase : phase;
      else             phase <= 1'b0;
      if (is_int)      v0 <= take | phase;
      else if (is_dec) v0 <= take & phase;
      else             v0 <= take;
    end
  end

  hbf_taps #(.SW(SW), .TAPS(TAPS)) u_taps (
    .clk(clk), .rst(rst), .shift(shift), .din(din), .tap(tap_w)
  );

  hbf_mac #(.SW(SW), .CW(HB_CW), .TAPS(TAPS), .ACCW(32), .FRAC(HB_FRAC)) u_mac (
    .clk(clk), .rst(rst), .en(en), .v0(v0), .interp(is_int),
    .pass(~is_int & ~is_dec), .tap(tap_w),
    .out_valid(out_valid), .out_data(out_data)
  );

  hbf_align_delay #(.W(SW), .LW(DLY_W)) u_align (
    .clk(clk), .rst(rst), .en(en), .len(dly_len), .din(aux_in), .dout(aux_out)
  );

  // consecutive advancing cycles since reset, for the latency check
  always_ff @(posedge clk) begin
    if (rst || !en) run_q <= '0;
    else if (run_q != 3'd7) run_q <= run_q + 3'd1;
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  interp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (is_int && in_valid && in_ready) |=> !in_ready);

  // R4
  dec_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (is_dec && out_valid && out_ready) |=> !out_valid);

  // R2
  pass_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q >= 3'd6 && mode == MODE_PASS && $past(mode, 6) == MODE_PASS
     && $past(in_valid && in_ready, 6))
    |-> (out_valid && out_data == $past(in_data, 6)));
endmodule

// File: tb/sim_hbf_rate_filter.sv
module sim_hbf_rate_filter;
  localparam int CLK_PERIOD = 10;
  localparam int C [14] = '{1273, -380, 210, -130, 85, -56, 37, -24, 16, -10, 6, -4, 2, -1};

  logic clk = 0, rst = 1;
  logic [1:0] mode = 0;
  logic in_valid = 0, out_ready = 1;
  logic signed [12:0] in_data = 0;
  logic in_ready, out_valid;
  logic signed [12:0] out_data;
  logic [6:0] dly_len = 0;
  logic signed [12:0] aux_in = 0;
  logic [12:0] aux_out;

  int vectors = 0, miss = 0, cycles = 0;
  int hist [55];
  int ahist [128];
  bit ev [6];
  int ed [6];
  bit iphase, dphase, prev_r;
  int aux_cnt = 0;
  logic [15:0] lf = 16'hACE1;

  hbf_rate_filter u0 (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .dly_len(dly_len), .aux_in(aux_in), .aux_out(aux_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int fir(input int s);
    int a;
    a = 2048 * hist[27];
    for (int m = 0; m < 14; m++) a += C[m] * (hist[27-(2*m+1)] + hist[27+(2*m+1)]);
    a = (a + (1 << (s - 1))) >>> s;
    if (a > 4095) a = 4095;
    if (a < -4096) a = -4096;
    return a;
  endfunction

  function automatic int rnd13();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return int'($signed(lf[12:0]));
  endfunction

  task automatic push(input int x);
    for (int i = 54; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = 1; aux_in = 0; mode = m;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 55; i++) hist[i] = 0;
    for (int i = 0; i < 128; i++) ahist[i] = 0;
    for (int i = 0; i < 6; i++) begin ev[i] = 0; ed[i] = 0; end
    iphase = 0; dphase = 0; prev_r = 1;
    #1;
    vectors++;
    if (out_valid !== 1'b0) begin
      miss++; $display("FAIL R9: out_valid %0b expected 0", out_valid);
    end
  endtask

  task automatic cyc(input bit iv, input int x, input bit r, input string tag);
    bit rdy, acc, nv;
    int nval;
    @(negedge clk);
    vectors++;
    if (out_valid !== ev[5] || (ev[5] && int'(out_data) != ed[5])) begin
      miss++;
      $display("FAIL %s: valid %0b data %0d expected valid %0b data %0d",
               tag, out_valid, out_data, ev[5], ed[5]);
    end
    if (prev_r) for (int i = 127; i > 0; i--) ahist[i] = ahist[i-1];
    ahist[0] = ((aux_cnt * 37) % 8192) - 4096;
    aux_cnt++;
    aux_in = ahist[0][12:0];
    in_valid = iv; in_data = x[12:0]; out_ready = r;
    #1;
    rdy = r && !(mode == 2'd1 && iphase);
    vectors++;
    if (in_ready !== rdy) begin
      miss++; $display("FAIL R5/R7: in_ready %0b expected %0b", in_ready, rdy);
    end
    vectors++;
    if (int'($signed(aux_out)) != ahist[dly_len]) begin
      miss++; $display("FAIL R8: aux_out %0d expected %0d", $signed(aux_out), ahist[dly_len]);
    end
    prev_r = r;
    acc = iv && rdy;
    if (r) begin
      for (int i = 5; i > 0; i--) begin ev[i] = ev[i-1]; ed[i] = ed[i-1]; end
      nv = 0; nval = 0;
      case (mode)
        2'd1: begin
          if (iphase) begin push(0); nv = 1; iphase = 0; end
          else if (acc) begin push(x); nv = 1; iphase = 1; end
          nval = fir(11);
        end
        2'd2: begin
          if (acc) begin push(x); nv = dphase; dphase = ~dphase; end
          nval = fir(12);
        end
        default: if (acc) begin push(x); nv = 1; nval = x; end
      endcase
      ev[0] = nv; ed[0] = nval;
    end
  endtask

  initial begin
    do_reset(2'd0);
    // R1 R2: every 13-bit value through pass-through
    for (int x = -4096; x < 4096; x++) cyc(1, x, 1, "R1/R2");
    repeat (8) cyc(0, 0, 1, "R1/R2");
    // R8: delay lengths including both ends
    foreach (C[k]) if (k < 5) begin
      dly_len = (k == 0) ? 7'd0 : (k == 1) ? 7'd1 : (k == 2) ? 7'd37 : (k == 3) ? 7'd126 : 7'd127;
      repeat (300) cyc(0, 0, 1, "R8");
    end
    dly_len = 7'd5;
    // R3 R4: decimation with gaps
    do_reset(2'd2);
    for (int i = 0; i < 3000; i++) begin
      int v; v = rnd13();
      cyc(lf[14] | lf[3], v, 1, "R3/R4");
    end
    // R6: full-scale steps to force clamping
    for (int b = 0; b < 20; b++) for (int i = 0; i < 60; i++) cyc(1, (b % 2) ? 4095 : -4096, 1, "R6");
    // R5: interpolation, input offered every cycle
    do_reset(2'd1);
    for (int i = 0; i < 2000; i++) begin
      int v; v = rnd13();
      cyc(1, v, 1, "R5");
    end
    for (int b = 0; b < 10; b++) for (int i = 0; i < 80; i++) cyc(1, (b % 2) ? 4095 : -4096, 1, "R5/R6");
    // R7: back-pressure in each mode
    for (int m = 0; m < 3; m++) begin
      do_reset(2'(m));
      for (int i = 0; i < 1500; i++) begin
        int v; v = rnd13();
        cyc(lf[9], v, lf[5] | lf[11], "R7");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        miss++;
        $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
      end
    end
  end
endmodule